// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that a processor drives through a small 32-bit register window. Software picks a target by writing a one-cold select field in the mode register, places a word in the transmit register, and collects the reply from the receive register. Each frame is 8 to 16 bits long and goes out most significant bit first on SCK/MOSI, while MISO is captured at the same time. Clock polarity, capture edge, clock divisor and frame length are held separately for each of the four chip-select lines, so targets with different needs can share one bus without reprogramming.

Status flags report an empty transmit holding register, a full receive register, an overrun, a fully idle transmitter and the enable state. A mask register routes any of the first group to a single interrupt line. An optional stall mode holds back the next frame until the previous received word has been read, so a slow reader never loses data. A hold option keeps the chip select low across frames until software marks the last transfer.

Top module: `spi_master`

## Requirements
- R1: After reset or a control write with bit 7 set, status (offset 0x10) reads 0x0000_0202, the mode register (0x04), every select config (0x30 + 4*n) and the mask (0x1C) read 0, all cs_n lines are high, and offset 0xFC returns the VERSION parameter.
- R2: The frame-length code in bits 7:4 of a select config gives 8 + code bits for codes 0 to 8 and 8 bits for codes 9 to 15; the received word sits right-aligned in bits 15:0 of offset 0x08 with all higher bits zero.
- R3: Data leaves MSB first; the idle SCK level equals bit 0 (polarity) of the active config; with bit 1 set MISO is captured on the leading SCK edge and MOSI changes on the trailing edge, with bit 1 clear MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R4: Every SCK half period lasts exactly D bus cycles, D being bits 15:8 of the active config, and D = 0 behaves as D = 1.
- R5: Mode bits 19:16 hold a one-cold field whose lowest zero bit n selects cs_n[n]; only that line goes low, exactly D bus cycles before the first SCK edge, and at most one line is ever low.
- R6: The line rises once the shifter is idle with no word pending, unless bit 3 of the active config is set; in that case it stays low until a control write with bit 24 set.
- R7: Control bit 0 enables and bit 1 disables (disable wins); status bit 16 shows the state; frames start only when enabled and mode bit 0 (master) is set; disabling raises cs_n at the next clock edge and aborts a frame.
- R8: A write to offset 0x0C clears status bit 1, which sets again when the word moves to the shifter; status bit 9 is set only when no word is held and the shifter is idle.
- R9: A finished frame sets status bit 0; if bit 0 was still set and no read of 0x08 happens in that cycle, status bit 3 (overrun) sets; a read of 0x08 clears both.
- R10: With mode bit 5 set, a pending word is not moved while status bit 0 is set, so no overrun arises.
- R11: A write to 0x14 sets mask bits, a write to 0x18 clears them, 0x1C reads them back, and irq is high when any of status bits 0, 1, 3, 9 is both set and masked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The hardest state to reach from the ports is a word parked in the holding register while the stall mode waits on an unread receive word, with no overrun growing in the background. The stimulus fills the receive register, queues a second word with the stall bit set, idles for a long stretch and checks that neither status bit 1 nor bit 3 moves, then reads the receive register and watches the held frame run. Random frames across all four selects, both polarities, both capture edges, divisors including zero and reserved length codes are checked against a bench-side target model that captures MOSI and returns its own MISO pattern.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  localparam int CS_N   = 4;
  localparam int WORD_W = 16;

  // Frame length in bits from a 4-bit length code; reserved codes fall back to 8.
  function automatic logic [4:0] frame_bits(input logic [3:0] code);
    if (code <= 4'd8) return 5'(code) + 5'd8;
    return 5'd8;
  endfunction

  // Half-period length in bus cycles; zero is promoted to one.
  function automatic logic [7:0] eff_div(input logic [7:0] raw);
    return (raw == 8'd0) ? 8'd1 : raw;
  endfunction

  // Index of the lowest zero in the one-cold select field.
  function automatic logic [1:0] cs_index(input logic [CS_N-1:0] field);
    logic [1:0] idx;
    idx = 2'd0;
    for (int i = CS_N - 1; i >= 0; i--) begin
      if (!field[i]) idx = 2'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (clr || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W     = 16,
  parameter int CNT_W = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             start,
  input  logic [W-1:0]     word,
  input  logic [CNT_W-1:0] nbits,
  input  logic [DIV_W-1:0] div,
  input  logic             cpha,
  input  logic             miso,
  output logic             busy,
  output logic             ph,
  output logic             mosi,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  localparam int EC_W = CNT_W + 1;

  logic [CNT_W-1:0] nb_q;
  logic [DIV_W-1:0] div_q;
  logic             cpha_q;
  logic [EC_W-1:0]  ec;
  logic [W-1:0]     sreg;
  logic [W-1:0]     aligned;
  logic             tick;
  logic             leading;
  logic             last_edge;

  spi_half_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .clr(clr), .run(busy), .div(div_q), .tick(tick)
  );

  always_comb aligned = word << (W - int'(nbits));
  assign leading   = !ph;
  assign last_edge = tick && (ec == {nb_q, 1'b0} - EC_W'(1));

  always_ff @(posedge clk) begin
    if (clr) begin
      busy <= 1'b0; ph <= 1'b0; mosi <= 1'b0; done <= 1'b0;
      ec <= '0; sreg <= '0; rx_word <= '0;
      nb_q <= CNT_W'(8); div_q <= DIV_W'(1); cpha_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; ph <= 1'b0; ec <= '0; rx_word <= '0;
        nb_q <= nbits; div_q <= div; cpha_q <= cpha;
        if (!cpha) begin
          mosi <= aligned[W-1];
          sreg <= aligned << 1;
        end else begin
          sreg <= aligned;
        end
      end else if (busy && tick) begin
        ph <= ~ph;
        ec <= ec + EC_W'(1);
        if (leading == cpha_q) begin
          mosi <= sreg[W-1];
          sreg <= sreg << 1;
        end else begin
          rx_word <= {rx_word[W-2:0], miso};
        end
        if (last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_master.sv
module spi_master
  import spi_master_pkg::*;
#(
  parameter logic [31:0] VERSION = 32'h0000_0102
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);
  localparam logic [31:0] MODE_BITS = 32'h000F_0031;
  localparam logic [15:0] CFG_BITS  = 16'hFFFB;
  localparam logic [9:0]  IRQ_BITS  = 10'h20B;

  // Register-bus decode
  logic wr_ctl, wr_mode, wr_tdr, wr_ier, wr_idr, wr_cfg, rx_rd;
  assign wr_ctl  = bus_wr && bus_addr == 8'h00;
  assign wr_mode = bus_wr && bus_addr == 8'h04;
  assign wr_tdr  = bus_wr && bus_addr == 8'h0C;
  assign wr_ier  = bus_wr && bus_addr == 8'h14;
  assign wr_idr  = bus_wr && bus_addr == 8'h18;
  assign wr_cfg  = bus_wr && bus_addr[7:4] == 4'h3 && bus_addr[1:0] == 2'b00;
  assign rx_rd   = bus_rd && bus_addr == 8'h08;

  logic ctl_en, ctl_dis, ctl_rst, ctl_last, clr;
  assign ctl_en   = wr_ctl && bus_wdata[0];
  assign ctl_dis  = wr_ctl && bus_wdata[1];
  assign ctl_rst  = wr_ctl && bus_wdata[7];
  assign ctl_last = wr_ctl && bus_wdata[24];
  assign clr      = !rst_n || ctl_rst;

  // State
  logic        en_q, tx_full, rx_full, ovr_q, last_pend, cs_act;
  logic [31:0] mode_q;
  logic [15:0] cfg_q [CS_N];
  logic [15:0] tx_hold, rx_data;
  logic [9:0]  imr_q;

  // Active select and its configuration
  logic [1:0]  sel;
  logic [15:0] cfg_sel;
  logic        sel_cpol, sel_keep;
  assign sel      = cs_index(mode_q[19:16]);
  assign cfg_sel  = cfg_q[sel];
  assign sel_cpol = cfg_sel[0];
  assign sel_keep = cfg_sel[3];

  // Engine handshake
  logic        sh_busy, sh_ph, sh_mosi, sh_done;
  logic [15:0] sh_rx;
  logic        tx_load, tx_empty, cs_release;

  assign tx_load = en_q && mode_q[0] && tx_full && !sh_busy &&
                   !(mode_q[5] && rx_full) && !ctl_dis && !ctl_rst;
  assign tx_empty   = !tx_full && !sh_busy;
  assign cs_release = cs_act && tx_empty && (!sel_keep || last_pend);

  spi_shift_engine #(.W(WORD_W), .CNT_W(5), .DIV_W(8)) u_eng (
    .clk(clk), .clr(clr || ctl_dis), .start(tx_load), .word(tx_hold),
    .nbits(frame_bits(cfg_sel[7:4])), .div(eff_div(cfg_sel[15:8])),
    .cpha(!cfg_sel[1]), .miso(miso), .busy(sh_busy), .ph(sh_ph),
    .mosi(sh_mosi), .done(sh_done), .rx_word(sh_rx)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q <= 1'b0; mode_q <= '0; tx_hold <= '0; tx_full <= 1'b0;
      rx_data <= '0; rx_full <= 1'b0; ovr_q <= 1'b0; imr_q <= '0;
      last_pend <= 1'b0; cs_act <= 1'b0;
      for (int i = 0; i < CS_N; i++) cfg_q[i] <= '0;
    end else begin
      if (ctl_dis)     en_q <= 1'b0;
      else if (ctl_en) en_q <= 1'b1;
      if (wr_mode) mode_q <= bus_wdata & MODE_BITS;
      if (wr_cfg)  cfg_q[bus_addr[3:2]] <= bus_wdata[15:0] & CFG_BITS;
      if (wr_tdr) begin
        tx_hold <= bus_wdata[15:0];
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end
      if (sh_done) begin
        rx_data <= sh_rx;
        rx_full <= 1'b1;
        if (rx_full && !rx_rd) ovr_q <= 1'b1;
        else if (rx_rd)        ovr_q <= 1'b0;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (wr_ier) imr_q <= imr_q | (bus_wdata[9:0] & IRQ_BITS);
      if (wr_idr) imr_q <= imr_q & ~bus_wdata[9:0];
      if (ctl_dis || cs_release) last_pend <= 1'b0;
      else if (ctl_last)         last_pend <= 1'b1;
      if (ctl_dis)         cs_act <= 1'b0;
      else if (tx_load)    cs_act <= 1'b1;
      else if (cs_release) cs_act <= 1'b0;
    end
  end

  logic [31:0] status;
  assign status = {15'b0, en_q, 6'b0, tx_empty, 5'b0, ovr_q, 1'b0, !tx_full, rx_full};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h04:   bus_rdata = mode_q;
      8'h08:   bus_rdata = {16'b0, rx_data};
      8'h10:   bus_rdata = status;
      8'h1C:   bus_rdata = {22'b0, imr_q};
      8'h30, 8'h34, 8'h38, 8'h3C: bus_rdata = {16'b0, cfg_q[bus_addr[3:2]]};
      8'hFC:   bus_rdata = VERSION;
      default: bus_rdata = '0;
    endcase
  end

  assign irq  = |(status[9:0] & imr_q);
  assign sck  = sel_cpol ^ sh_ph;
  assign mosi = sh_mosi;

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && sel == 2'(g));
  end
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cs_n,
  input logic       sck,
  input logic       cpol,
  input logic       busy,
  input logic       load,
  input logic       wait_rd,
  input logic       rx_full,
  input logic       ovr,
  input logic       rx_rd,
  input logic       done,
  input logic       dis_wr
);
  AST_CS_ONECOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R5

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(wait_rd && rx_full)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !done |=> !rx_full && !ovr); // R9

  AST_OVR_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done)); // R9

  AST_DIS_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> cs_n == 4'hF); // R7

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R8
endmodule

bind spi_master spi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .cpol(sel_cpol),
  .busy(sh_busy), .load(tx_load), .wait_rd(mode_q[5]), .rx_full(rx_full),
  .ovr(ovr_q), .rx_rd(rx_rd), .done(sh_done), .dis_wr(ctl_dis)
);

// File: tb/spi_master_tb.sv
`timescale 1ns/1ps
module spi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  localparam logic [31:0] VER = 32'h0000_0102;

  spi_master #(.VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #2 clk = ~clk;

  int nvec = 0, nfail = 0;

  function automatic int bits_of(input int code);
    return (code <= 8) ? code + 8 : 8;
  endfunction
  function automatic int mask_of(input int nb);
    return (1 << nb) - 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h10, st);
      if (st[9]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Bench-side target model
  logic [15:0] s_tx = '0, s_rx = '0, s_got = '0;
  int  s_nb = 8, s_cnt = 0, s_lc = 0;
  logic s_cpol = 1'b0, s_cpha = 1'b0;
  logic cs_prev = 1'b0, sck_prev = 1'b0;
  time  t_cs = 0, t_e1 = 0, t_e2 = 0;
  int   n_edge = 0;
  wire  cs_low = ~&cs_n;

  always @(sck or cs_low) begin
    if (cs_low && !cs_prev) begin
      t_cs = $time; n_edge = 0; s_cnt = 0; s_rx = '0;
      if (!s_cpha) begin miso = s_tx[s_nb-1]; s_lc = 1; end
      else s_lc = 0;
    end
    if (cs_low && sck != sck_prev) begin
      n_edge++;
      if (n_edge == 1) t_e1 = $time;
      if (n_edge == 2) t_e2 = $time;
      if ((sck != s_cpol) != s_cpha) begin
        s_rx = {s_rx[14:0], mosi};
        s_cnt++;
        if (s_cnt == s_nb) begin s_got = s_rx; s_cnt = 0; s_rx = '0; end
      end else begin
        miso = s_tx[s_nb-1-s_lc];
        s_lc = (s_lc + 1) % s_nb;
      end
    end
    cs_prev = cs_low; sck_prev = sck;
  end

  function automatic logic [31:0] cfg_word(input int dv, input int code, input logic keep,
                                           input logic ncpha, input logic cpol);
    return {16'b0, 8'(dv), 4'(code), 1'b0, 1'b0, 1'b0, 1'b0} |
           {28'b0, keep, 1'b0, ncpha, cpol};
  endfunction

  function automatic logic [31:0] mode_word(input int cs, input logic wait_rd);
    logic [3:0] f;
    f = ~(4'b1 << cs);
    return {12'b0, f, 10'b0, wait_rd, 1'b1, 3'b0, 1'b1};
  endfunction

  task automatic setup(input int cs, input int dv, input int code, input logic keep,
                       input logic ncpha, input logic cpol, input logic wait_rd,
                       input logic [15:0] sdata);
    wr(8'h30 + 8'(4*cs), cfg_word(dv, code, keep, ncpha, cpol));
    wr(8'h04, mode_word(cs, wait_rd));
    wr(8'h00, 32'h1);
    s_cpol = cpol; s_cpha = !ncpha; s_nb = bits_of(code); s_tx = sdata;
  endtask

  task automatic frame(input int cs, input int dv, input int code, input logic ncpha,
                       input logic cpol, input logic [15:0] data, input logic [15:0] sdata);
    logic [31:0] v;
    int d, m;
    d = (dv == 0) ? 1 : dv;
    m = mask_of(bits_of(code));
    setup(cs, dv, code, 1'b0, ncpha, cpol, 1'b0, sdata);
    chk("R3 idle sck level", {31'b0, sck}, {31'b0, cpol});
    wr(8'h0C, {16'b0, data});
    wait_idle();
    rd(8'h08, v);
    chk("R2 R3 received word", v, 32'(sdata) & 32'(m));
    chk("R3 target captured MOSI", {16'b0, s_got}, 32'(data) & 32'(m));
    chk("R4 half period", 32'(t_e2 - t_e1), 32'(4*d));
    chk("R5 cs lead time", 32'(t_e1 - t_cs), 32'(4*d));
    chk("R6 cs released", {28'b0, cs_n}, 32'hF);
  endtask

  initial begin
    #(4*150000);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, v); chk("R1 status after reset", v, 32'h0000_0202);
    rd(8'h04, v); chk("R1 mode after reset", v, 32'h0);
    rd(8'h1C, v); chk("R1 mask after reset", v, 32'h0);
    rd(8'h30, v); chk("R1 config after reset", v, 32'h0);
    rd(8'hFC, v); chk("R1 version", v, VER);
    chk("R1 cs idle", {28'b0, cs_n}, 32'hF);

    // R2 R3 R4 directed corners: reserved code, divisor zero, 16-bit frame
    frame(0, 0, 12, 1'b1, 1'b0, 16'hA5C3, 16'h3C5A);
    frame(3, 2, 8, 1'b0, 1'b1, 16'hBEEF, 16'h1234);
    frame(1, 1, 0, 1'b0, 1'b0, 16'h00F1, 16'h0080);

    // Random frames
    for (int k = 0; k < 24; k++) begin
      frame($urandom % 4, $urandom % 7, $urandom % 16, 1'($urandom), 1'($urandom),
            16'($urandom), 16'($urandom));
    end

    // R9 overrun and clearing by read
    setup(2, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0055);
    wr(8'h0C, 32'h11); wait_idle();
    wr(8'h0C, 32'h22); wait_idle();
    rd(8'h10, v); chk("R9 overrun set", v, 32'h0001_020B);
    rd(8'h08, v); chk("R9 latest word kept", v, 32'h55);
    rd(8'h10, v); chk("R9 read clears full and overrun", v, 32'h0001_0202);

    // R10 stall until read
    setup(0, 1, 0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0066);
    wr(8'h0C, 32'h33); wait_idle();
    wr(8'h0C, 32'h44);
    repeat (100) @(negedge clk);
    rd(8'h10, v); chk("R10 R8 word held, no overrun", v, 32'h0001_0001);
    rd(8'h08, v); chk("R10 first word", v, 32'h66);
    wait_idle();
    rd(8'h10, v); chk("R10 held frame ran", v, 32'h0001_0203);
    chk("R10 target saw held word", {16'b0, s_got}, 32'h44);
    rd(8'h08, v);

    // R6 keep-asserted then last transfer
    setup(1, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0011);
    wr(8'h0C, 32'h77); wait_idle();
    chk("R6 cs held low", {28'b0, cs_n}, 32'hD);
    wr(8'h00, 32'h0100_0000);
    repeat (2) @(negedge clk);
    chk("R6 last transfer releases cs", {28'b0, cs_n}, 32'hF);
    rd(8'h08, v);

    // R7 disable mid-frame, and no transfer while disabled
    setup(0, 20, 8, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    wr(8'h0C, 32'hFFFF);
    repeat (30) @(negedge clk);
    wr(8'h00, 32'h2);
    chk("R7 cs rises on disable", {28'b0, cs_n}, 32'hF);
    rd(8'h10, v); chk("R7 disabled state", v & 32'h0001_0000, 32'h0);
    wr(8'h0C, 32'h5);
    repeat (60) @(negedge clk);
    rd(8'h10, v); chk("R7 R8 no transfer when disabled", v, 32'h0000_0000);
    chk("R7 cs stays high", {28'b0, cs_n}, 32'hF);

    // R1 software reset
    wr(8'h00, 32'h80);
    rd(8'h10, v); chk("R1 status after soft reset", v, 32'h0000_0202);
    rd(8'h34, v); chk("R1 config cleared", v, 32'h0);

    // R11 interrupt mask
    wr(8'h14, 32'h1);
    rd(8'h1C, v); chk("R11 mask readback", v, 32'h1);
    chk("R11 irq low before data", {31'b0, irq}, 32'h0);
    setup(0, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0009);
    wr(8'h0C, 32'h9); wait_idle();
    chk("R11 irq on receive full", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h1);
    @(negedge clk);
    chk("R11 irq masked off", {31'b0, irq}, 32'h0);
    rd(8'h1C, v); chk("R11 mask cleared", v, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule